// File: doc/BRIEF.md
# Quadrature-Capable Timer Channel

This block is a single 16-bit timer channel. In its normal mode it counts upward on a tick taken either from a divided system clock or from the rising edges of an external clock pin. In phase mode it follows a two-phase (quadrature) pair of inputs instead, and steps up or down according to which phase leads.

Two general registers sit beside the counter. Each can act as a compare value or as a capture register, and either one can be chosen to clear the count. The clear fires on a compare match or on a capture. A single sticky flag records a wrap in either direction. Software uses it with a read-then-write-zero sequence.

A synchronous register port reaches every register. The counter and both general registers accept whole-word writes or writes to either byte alone. A standby input holds the count at zero.

Top module: `phase_timer`

## Requirements
- R1: After reset the counter reads 0x0000, the wrap flag reads 0, and both general registers read 0xFFFF.
- R2: With control register (address 0) bits [2:0] = 000, 001, 010 or 011, phase mode off and clear select 00, the counter advances by exactly 16, 8, 4 or 2 over any 16 consecutive clocks.
- R3: With control bits [2:0] = 1xx, the counter steps once per rising edge of the external clock input, visible within 4 clocks of the edge. Falling edges are not counted.
- R4: With control bit 3 set (phase mode), the counter steps up once on each transition of the sequence (a,b) 00→10→11→01→00 and down once on each transition of the reverse sequence.
- R5: In phase mode, a transition where both phase inputs change together leaves the counter unchanged.
- R6: Control bits [5:4] choose the clear source: 00 none, 01 register A, 10 register B. A register in compare mode whose value equals the count on a counting step loads the counter with 0 in place of the step, so the count cycles 0..N.
- R7: Control bit 6 (for A) or bit 7 (for B) puts that register in capture mode. A rising edge on its capture input copies the counter into it. If that register is the clear source, the counter becomes 0 in the same cycle.
- R8: An upward step from 0xFFFF to 0x0000 sets the wrap flag (status register, address 1, bit 0).
- R9: A downward step in phase mode from 0x0000 to 0xFFFF sets the same wrap flag.
- R10: Writing 0 to status bit 0 clears the flag only when a read strobe (reg_rd) of the status register saw it as 1 since the last status write. Otherwise the flag stays set. A wrap in the same cycle as the clearing write keeps it set.
- R11: The counter (address 2), register A (3) and register B (4) take writes per byte: reg_wbe[1] writes bits [15:8] and reg_wbe[0] writes bits [7:0].
- R12: While standby is high the counter holds 0x0000. Counting resumes from 0 once it is released.
- R13: A write to the counter takes priority over a count step or a clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | Holds the counter at zero |
| ext_clk_in | input | 1 | External count clock |
| ph_a_in | input | 1 | Phase input A |
| ph_b_in | input | 1 | Phase input B |
| cap_a_in | input | 1 | Capture trigger for register A |
| cap_b_in | input | 1 | Capture trigger for register B |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (arms flag clearing) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_wbe | input | 2 | Byte enables, bit 1 upper byte |
| reg_rdata | output | 16 | Read data for reg_addr |
| wrap_flag | output | 1 | Sticky wrap flag |

## Verification
The bench builds the block with its defaults: a 16-bit counter and two synchroniser stages. With 16 bits, a single preloaded write puts the counter one step from either wrap, so both wrap directions come within a few cycles. With two stages, each pin event shows up in the count after a fixed three-clock delay, so every pin-driven check can wait four clocks and then compare exact values. The prescaler ratios go through a table of 16-clock windows, which hold the same number of ticks whatever phase the divider starts in.

// File: rtl/phase_timer.sv
module phase_timer #(
  parameter int CNT_W  = 16,
  parameter int SYNC_N = 2,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              standby,
  input  logic              ext_clk_in,
  input  logic              ph_a_in,
  input  logic              ph_b_in,
  input  logic              cap_a_in,
  input  logic              cap_b_in,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  input  logic [1:0]        reg_wbe,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic              wrap_flag
);
  localparam int NIN = 5;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(0), A_STS = ADDR_W'(1),
                                A_CNT = ADDR_W'(2), A_GRA = ADDR_W'(3), A_GRB = ADDR_W'(4);

  function automatic logic [CNT_W-1:0] merge(input logic [CNT_W-1:0] o, input logic [CNT_W-1:0] n,
                                             input logic [1:0] be);
    merge = o;
    if (be[0]) merge[7:0] = n[7:0];
    if (be[1]) merge[CNT_W-1:8] = n[CNT_W-1:8];
  endfunction

  // input synchronisers, bit order {cap_b, cap_a, ph_b, ph_a, ext}
  logic [NIN-1:0] in_raw, sync_q [SYNC_N], prev_q, cur;
  assign in_raw = {cap_b_in, cap_a_in, ph_b_in, ph_a_in, ext_clk_in};
  assign cur    = sync_q[SYNC_N-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < SYNC_N; i++) sync_q[i] <= '0;
      prev_q <= '0;
    end else begin
      sync_q[0] <= in_raw;
      for (int i = 1; i < SYNC_N; i++) sync_q[i] <= sync_q[i-1];
      prev_q <= cur;
    end

  logic rise_ext, rise_ca, rise_cb;
  assign rise_ext = cur[0] & ~prev_q[0];
  assign rise_ca  = cur[3] & ~prev_q[3];
  assign rise_cb  = cur[4] & ~prev_q[4];

  // registers
  logic [7:0]       ctrl_q;
  logic [CNT_W-1:0] cnt_q, gra_q, grb_q;
  logic [2:0]       div_q;
  logic             armed_q;

  logic [2:0] clk_sel;
  logic [1:0] clr_sel;
  logic       ph_mode, a_cap, b_cap;
  assign clk_sel = ctrl_q[2:0];
  assign ph_mode = ctrl_q[3];
  assign clr_sel = ctrl_q[5:4];
  assign a_cap   = ctrl_q[6];
  assign b_cap   = ctrl_q[7];

  logic wr_ctl, wr_sts, wr_cnt, wr_a, wr_b, rd_sts;
  assign wr_ctl = reg_wr && reg_addr == A_CTL && reg_wbe[0];
  assign wr_sts = reg_wr && reg_addr == A_STS && reg_wbe[0];
  assign wr_cnt = reg_wr && reg_addr == A_CNT && |reg_wbe;
  assign wr_a   = reg_wr && reg_addr == A_GRA && |reg_wbe;
  assign wr_b   = reg_wr && reg_addr == A_GRB && |reg_wbe;
  assign rd_sts = reg_rd && reg_addr == A_STS;

  // prescaler tick
  logic [2:0] div_mask;
  logic       tick_int;
  assign div_mask = 3'((4'd1 << clk_sel[1:0]) - 4'd1);
  assign tick_int = &(div_q | ~div_mask);

  // quadrature decode, {a,b} old then new
  logic [3:0] ph_tr;
  logic       ph_up, ph_dn;
  assign ph_tr = {prev_q[1], prev_q[2], cur[1], cur[2]};
  always_comb begin
    ph_up = 1'b0;
    ph_dn = 1'b0;
    case (ph_tr)
      4'b0010, 4'b1011, 4'b1101, 4'b0100: ph_up = 1'b1;
      4'b0001, 4'b0111, 4'b1110, 4'b1000: ph_dn = 1'b1;
      default: ;
    endcase
  end

  logic cnt_up, cnt_dn, step, cap_a_ev, cap_b_ev, match_a, match_b, clr, wrap_ev;
  assign cnt_up   = ph_mode ? ph_up : (clk_sel[2] ? rise_ext : tick_int);
  assign cnt_dn   = ph_mode & ph_dn;
  assign step     = cnt_up | cnt_dn;
  assign cap_a_ev = a_cap & rise_ca;
  assign cap_b_ev = b_cap & rise_cb;
  assign match_a  = !a_cap && step && cnt_q == gra_q;
  assign match_b  = !b_cap && step && cnt_q == grb_q;
  assign clr      = (clr_sel == 2'b01 && (match_a || cap_a_ev)) ||
                    (clr_sel == 2'b10 && (match_b || cap_b_ev));
  assign wrap_ev  = !standby && !wr_cnt && !clr &&
                    ((cnt_up && cnt_q == '1) || (cnt_dn && cnt_q == '0));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl_q <= '0;
      div_q  <= '0;
    end else begin
      div_q <= div_q + 3'd1;
      if (wr_ctl) ctrl_q <= reg_wdata[7:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                cnt_q <= '0;
    else if (standby)          cnt_q <= '0;
    else if (wr_cnt)           cnt_q <= merge(cnt_q, reg_wdata, reg_wbe);
    else if (clr)              cnt_q <= '0;
    else if (cnt_up)           cnt_q <= cnt_q + ONE;
    else if (cnt_dn)           cnt_q <= cnt_q - ONE;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      gra_q <= '1;
      grb_q <= '1;
    end else begin
      if (wr_a)          gra_q <= merge(gra_q, reg_wdata, reg_wbe);
      else if (cap_a_ev) gra_q <= cnt_q;
      if (wr_b)          grb_q <= merge(grb_q, reg_wdata, reg_wbe);
      else if (cap_b_ev) grb_q <= cnt_q;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wrap_flag <= 1'b0;
      armed_q   <= 1'b0;
    end else begin
      if (wrap_ev)                                   wrap_flag <= 1'b1;
      else if (wr_sts && !reg_wdata[0] && armed_q)  wrap_flag <= 1'b0;
      if (wr_sts)                   armed_q <= 1'b0;
      else if (rd_sts && wrap_flag) armed_q <= 1'b1;
    end

  always_comb
    case (reg_addr)
      A_CTL:   reg_rdata = {{(CNT_W-8){1'b0}}, ctrl_q};
      A_STS:   reg_rdata = {{(CNT_W-1){1'b0}}, wrap_flag};
      A_CNT:   reg_rdata = cnt_q;
      A_GRA:   reg_rdata = gra_q;
      A_GRB:   reg_rdata = grb_q;
      default: reg_rdata = '0;
    endcase

  a_r12_standby_zero: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> cnt_q == '0);

  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!standby && !wr_cnt) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + ONE ||
                               cnt_q == $past(cnt_q) - ONE || cnt_q == '0));

  a_r8_up_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!standby && !wr_cnt && !clr && cnt_up && cnt_q == '1) |=> (cnt_q == '0 && wrap_flag));

  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_flag && !wr_sts) |=> wrap_flag);

  a_r5_invalid_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_mode && cur[1] != prev_q[1] && cur[2] != prev_q[2] && !standby && !wr_cnt && !clr)
      |=> $stable(cnt_q));

  a_r7_capture_a: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_a_ev && !wr_a) |=> gra_q == $past(cnt_q));
endmodule

// File: tb/phase_timer_tb_top.sv
`timescale 1ns/1ps
module phase_timer_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, standby = 1'b0;
  logic ext_clk_in = 1'b0, ph_a_in = 1'b0, ph_b_in = 1'b0, cap_a_in = 1'b0, cap_b_in = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic [1:0] reg_wbe = '0;
  logic wrap_flag;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  phase_timer dut_i (.clk, .rst_n, .standby, .ext_clk_in, .ph_a_in, .ph_b_in, .cap_a_in,
                     .cap_b_in, .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_wbe,
                     .reg_rdata, .wrap_flag);

  // {clk_sel[2:0], expected advance over 16 clocks}
  localparam logic [7:0] PRESC_TBL [4] = '{{3'd0, 5'd16}, {3'd1, 5'd8}, {3'd2, 5'd4}, {3'd3, 5'd2}};

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_wbe = be;
    @(negedge clk);
    reg_wr = 1'b0; reg_wbe = 2'b00;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_check(input string tag, input logic [15:0] ctl, input logic [2:0] ra,
                             input logic [15:0] lim);
    logic [15:0] s0, s1, mx;
    int bad = 0;
    wr(3'd0, ctl, 2'b11);
    wr(ra, lim, 2'b11);
    wr(3'd2, 16'h0000, 2'b11);
    rd(3'd2, s0);
    mx = s0;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      rd(3'd2, s1);
      if (s1 != ((s0 == lim) ? 16'h0000 : s0 + 16'd1)) bad++;
      if (s1 > mx) mx = s1;
      s0 = s1;
    end
    chk({tag, " sequence errors"}, 16'(bad), 16'd0);
    chk({tag, " peak equals compare value"}, mx, lim);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++; n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] v, v0;
    wait_n(3);
    rst_n = 1'b1;
    rd(3'd2, v); chk("R1 counter after reset", v, 16'h0000);
    rd(3'd1, v); chk("R1 flag after reset", v, 16'h0000);
    rd(3'd3, v); chk("R1 reg A after reset", v, 16'hFFFF);
    rd(3'd4, v); chk("R1 reg B after reset", v, 16'hFFFF);

    // R2 prescaler table
    for (int i = 0; i < 4; i++) begin
      wr(3'd0, {13'd0, PRESC_TBL[i][7:5]}, 2'b11);
      rd(3'd2, v0);
      wait_n(16);
      rd(3'd2, v);
      chk($sformatf("R2 advance sel %0d", PRESC_TBL[i][7:5]), v - v0, {11'd0, PRESC_TBL[i][4:0]});
    end

    // R13 write wins over count
    wr(3'd0, 16'h0000, 2'b11);
    wr(3'd2, 16'h4000, 2'b11);
    rd(3'd2, v); chk("R13 write beats count", v, 16'h4000);

    // R11 byte writes, external clock idle
    wr(3'd0, 16'h0004, 2'b11);
    wr(3'd2, 16'h0000, 2'b11);
    wr(3'd2, 16'hAB00, 2'b10);
    rd(3'd2, v); chk("R11 upper byte", v, 16'hAB00);
    wr(3'd2, 16'h12CD, 2'b01);
    rd(3'd2, v); chk("R11 lower byte", v, 16'hABCD);
    wr(3'd3, 16'h5A00, 2'b10);
    rd(3'd3, v); chk("R11 reg A upper byte", v, 16'h5AFF);

    // R3 external clock
    ext_clk_in = 1'b1; wait_n(4);
    rd(3'd2, v); chk("R3 rising edge counted", v, 16'hABCE);
    ext_clk_in = 1'b0; wait_n(4);
    rd(3'd2, v); chk("R3 falling edge ignored", v, 16'hABCE);

    // R8 upward wrap
    wr(3'd2, 16'hFFFF, 2'b11);
    ext_clk_in = 1'b1; wait_n(4);
    rd(3'd2, v); chk("R8 wrap to zero", v, 16'h0000);
    rd(3'd1, v); chk("R8 flag set", v, 16'h0001);
    ext_clk_in = 1'b0; wait_n(4);

    // R10 clear protocol
    wr(3'd1, 16'h0000, 2'b11);
    rd(3'd1, v); chk("R10 write without read keeps flag", v, 16'h0001);
    @(negedge clk); reg_addr = 3'd1; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0;
    wr(3'd1, 16'h0000, 2'b11);
    rd(3'd1, v); chk("R10 read then write clears", v, 16'h0000);

    // R4 phase counting
    wr(3'd0, 16'h0008, 2'b11);
    wr(3'd2, 16'h0100, 2'b11);
    ph_a_in = 1'b1; wait_n(4);
    ph_b_in = 1'b1; wait_n(4);
    ph_a_in = 1'b0; wait_n(4);
    ph_b_in = 1'b0; wait_n(4);
    rd(3'd2, v); chk("R4 A leads B counts up", v, 16'h0104);
    ph_b_in = 1'b1; wait_n(4);
    ph_a_in = 1'b1; wait_n(4);
    ph_b_in = 1'b0; wait_n(4);
    ph_a_in = 1'b0; wait_n(4);
    rd(3'd2, v); chk("R4 B leads A counts down", v, 16'h0100);

    // R5 invalid transitions
    ph_a_in = 1'b1; ph_b_in = 1'b1; wait_n(4);
    ph_a_in = 1'b0; ph_b_in = 1'b0; wait_n(4);
    rd(3'd2, v); chk("R5 double change ignored", v, 16'h0100);

    // R9 downward wrap
    wr(3'd2, 16'h0000, 2'b11);
    ph_b_in = 1'b1; wait_n(4);
    rd(3'd2, v); chk("R9 wrap to FFFF", v, 16'hFFFF);
    rd(3'd1, v); chk("R9 flag set on underflow", v, 16'h0001);
    ph_b_in = 1'b0; wait_n(4);

    // R6 compare clear
    clear_check("R6 clear by A", 16'h0010, 3'd3, 16'd5);
    clear_check("R6 clear by B", 16'h0020, 3'd4, 16'd3);

    // R7 capture
    wr(3'd0, 16'h0054, 2'b11);
    wr(3'd2, 16'h1234, 2'b11);
    cap_a_in = 1'b1; wait_n(4);
    rd(3'd3, v); chk("R7 capture into A", v, 16'h1234);
    rd(3'd2, v); chk("R7 capture clears counter", v, 16'h0000);
    cap_a_in = 1'b0;
    wr(3'd0, 16'h0084, 2'b11);
    wr(3'd2, 16'h0777, 2'b11);
    cap_b_in = 1'b1; wait_n(4);
    rd(3'd4, v); chk("R7 capture into B", v, 16'h0777);
    rd(3'd2, v); chk("R7 counter kept without clear", v, 16'h0777);
    cap_b_in = 1'b0;

    // R12 standby
    wr(3'd0, 16'h0000, 2'b11);
    standby = 1'b1; wait_n(3);
    rd(3'd2, v); chk("R12 standby holds zero", v, 16'h0000);
    standby = 1'b0; wait_n(3);
    rd(3'd2, v); chk("R12 resumes from zero", v, 16'h0003);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule